// File: doc/BRIEF.md
# Cluster Performance Counter Unit

This block counts hardware events for a group of processing cores. It has a parameterized bank of 32-bit event counters and one free-running 64-bit cycle counter. Each event counter is programmed with an event code. On every clock in which the event line with that code is high, the counter steps up by one. Software reaches the unit through a narrow synchronous register port. A one-cycle write strobe updates state at the clock edge, and read data is a combinational function of the address.

The event counters have no individual addresses. Software writes a counter index into a selector register and then reads or writes an event-type window and a count window. Counter enables, overflow interrupt enables and overflow flags all use bitmaps in which event counter i owns bit i and the cycle counter owns bit 31. Each bitmap is changed through a write-ones-to-set address and a write-ones-to-clear address. A counter that wraps from all ones to zero raises a sticky flag. The single level interrupt stays high while any flag meets its interrupt enable.

Top module: `pmon_unit`

## Requirements
- R1: After reset, every counter, enable, interrupt enable and overflow flag is zero and irq_o is low. The control word (address 0x0) reads the global run bit at bit 0, the event-counter count at bits 15:11, an ID code at bits 23:16 and an implementer code at bits 31:24. With the defaults (4 counters, ID 0x3C, implementer 0x5A) it reads 0x5A3C2000.
- R2: An event counter steps once per clock in which its chosen event line is high, but only while control bit 0 and its own enable bit are both set. The cycle counter steps every clock while control bit 0 and enable bit 31 are both set.
- R3: Writing ones to address 0x1 sets counter-enable bits and writing ones to address 0x2 clears them. Zero bits have no effect. Both addresses read back the enable mask, and bits for counters that are not implemented read zero.
- R4: An event counter programmed with event code 0x11 counts every clock, whatever the state of the event lines.
- R5: A counter stepping from all ones to zero sets its overflow flag: bit i for event counter i, bit 31 for the 64-bit cycle counter. The cycle counter carries from its low word into its high word.
- R6: The overflow flags read at address 0x4. Writing ones there clears those flags, writing ones to address 0x3 forces flags, and zero bits have no effect. A hardware overflow in the same clock as a clear leaves the flag set.
- R7: The interrupt-enable mask is set at address 0x6 and cleared at address 0x7, and both addresses read it back. irq_o is high exactly while some overflow flag and its interrupt enable are both set.
- R8: Writing control bit 1 zeroes all event counters and control bit 2 zeroes the cycle counter, in that clock and ahead of any increment. Both bits always read as zero.
- R9: The selector at address 0x5 holds a 5-bit index and reads it back. The event-type window (0xA) and count window (0xB) read and write the selected event counter. With index 31 the type window reads 0x11 and the count window reaches the low word of the cycle counter.
- R10: With a selector index at or above the counter count, other than 31, both windows read zero and writes to them change no counter.
- R11: A software write to a counter's value in the same clock as an increment loads the written value and raises no overflow.
- R12: Addresses 0xC and 0xD return the low and high halves of the 64-bit supported-event bitmap, and writes to them are ignored.
- R13: The cycle counter is read and written directly as a low word at 0x8 and a high word at 0x9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Write strobe, takes effect at the rising edge |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| evt_i | input | NUM_CODES | Per-clock event lines, indexed by event code |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
Two pairs of actions can land on the same clock edge. The first is a hardware wrap together with a software write-one-to-clear of the same overflow flag. The second is a counter increment together with a software write of that counter's value or a control-word reset. The bench raises the event line and issues the register write in the same driven cycle, so both reach one rising edge. Afterwards it reads back the flag, which must remain set, and the counter, which must hold the written value or zero with no new overflow.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int unsigned CNT_W       = 32;
  localparam int unsigned CYC_W       = 64;
  localparam int unsigned CYC_BIT     = 31;
  localparam int unsigned SEL_W       = 5;
  localparam int unsigned CODE_CYCLES = 32'h11;

  typedef enum logic [3:0] {
    A_CTRL    = 4'h0,
    A_EN_SET  = 4'h1,
    A_EN_CLR  = 4'h2,
    A_OVF_SET = 4'h3,
    A_OVF_CLR = 4'h4,
    A_SEL     = 4'h5,
    A_IEN_SET = 4'h6,
    A_IEN_CLR = 4'h7,
    A_CYC_LO  = 4'h8,
    A_CYC_HI  = 4'h9,
    A_EVTYPE  = 4'hA,
    A_EVVAL   = 4'hB,
    A_CAP_LO  = 4'hC,
    A_CAP_HI  = 4'hD
  } pmon_addr_e;
endpackage

// File: rtl/pmon_evcnt.sv
module pmon_evcnt
  import pmon_pkg::*;
#(
  parameter int unsigned NUM_CODES = 64,
  localparam int unsigned CODE_W   = $clog2(NUM_CODES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [NUM_CODES-1:0] evt_i,
  input  logic                 zero_i,
  input  logic                 type_we_i,
  input  logic                 val_we_i,
  input  logic [CNT_W-1:0]     wdata_i,
  output logic [CODE_W-1:0]    type_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 wrap_o
);
  logic [CODE_W-1:0] type_q, type_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              hit, inc;

  // Code 0x11 counts every clock; otherwise follow the chosen event line.
  assign hit = (type_q == CODE_W'(CODE_CYCLES)) ? 1'b1 : evt_i[type_q];
  assign inc = run_i & hit;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (zero_i) begin
      cnt_d = '0;
    end else if (val_we_i) begin
      cnt_d = wdata_i;
    end else if (inc) begin
      cnt_d  = cnt_q + CNT_W'(1);
      wrap_o = &cnt_q;
    end
    type_d = type_we_i ? wdata_i[CODE_W-1:0] : type_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      type_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      type_q <= type_d;
    end
  end

  assign type_o = type_q;
  assign cnt_o  = cnt_q;

  assert_wrap_to_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  assert_write_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_we_i && !zero_i) |=> (cnt_q == $past(wdata_i)));
  assert_event_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> (cnt_q == '0));
  assert_gate_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !val_we_i && !zero_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pmon_cyccnt.sv
module pmon_cyccnt
  import pmon_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             zero_i,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CYC_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CYC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (zero_i) begin
      cnt_d = '0;
    end else if (lo_we_i || hi_we_i) begin
      if (lo_we_i) cnt_d[CNT_W-1:0]     = wdata_i;
      if (hi_we_i) cnt_d[CYC_W-1:CNT_W] = wdata_i;
    end else if (run_i) begin
      cnt_d  = cnt_q + CYC_W'(1);
      wrap_o = &cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_cyc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !zero_i && !lo_we_i && !hi_we_i) |=> (cnt_q == $past(cnt_q) + CYC_W'(1)));
  assert_cyc_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> (cnt_q == '0));
endmodule

// File: rtl/pmon_unit.sv
module pmon_unit
  import pmon_pkg::*;
#(
  parameter int unsigned NUM_CTR   = 4,
  parameter int unsigned NUM_CODES = 64,
  parameter logic [7:0]  ID_CODE   = 8'h3C,
  parameter logic [7:0]  IMPL_CODE = 8'h5A,
  parameter logic [63:0] CAP_MAP   = 64'h0000_0001_3E0A_0001
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [3:0]           reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [NUM_CODES-1:0] evt_i,
  output logic                 irq_o
);
  localparam int unsigned CODE_W = $clog2(NUM_CODES);
  localparam logic [31:0] VALID  = (32'h1 << CYC_BIT) | ((32'h1 << NUM_CTR) - 32'h1);

  logic              run_q, run_d;
  logic [31:0]       en_q, en_d, ien_q, ien_d, ovf_q, ovf_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [31:0]       wmask, ovf_clr, ovf_sw, hw_wrap;
  logic              ev_zero, cyc_zero, sel_is_cyc;
  logic              cyc_lo_we, cyc_hi_we, cyc_wrap;
  logic [CYC_W-1:0]  cyc_cnt;
  logic [NUM_CTR-1:0]             ev_wrap;
  logic [CNT_W-1:0]               ev_cnt  [NUM_CTR];
  logic [CODE_W-1:0]              ev_type [NUM_CTR];
  logic [31:0]       win_val, win_type;

  function automatic logic wr_at(pmon_addr_e a);
    return reg_we_i && (reg_addr_i == a);
  endfunction

  assign wmask    = reg_wdata_i & VALID;
  assign ev_zero  = wr_at(A_CTRL) & reg_wdata_i[1];
  assign cyc_zero = wr_at(A_CTRL) & reg_wdata_i[2];
  assign ovf_clr  = wr_at(A_OVF_CLR) ? wmask : '0;
  assign ovf_sw   = wr_at(A_OVF_SET) ? wmask : '0;
  assign sel_is_cyc = (sel_q == SEL_W'(CYC_BIT));

  // Next state of the control and bitmap registers.
  always_comb begin
    run_d = wr_at(A_CTRL) ? reg_wdata_i[0] : run_q;
    sel_d = wr_at(A_SEL) ? reg_wdata_i[SEL_W-1:0] : sel_q;
    en_d  = en_q;
    if (wr_at(A_EN_SET)) en_d = en_q | wmask;
    if (wr_at(A_EN_CLR)) en_d = en_q & ~wmask;
    ien_d = ien_q;
    if (wr_at(A_IEN_SET)) ien_d = ien_q | wmask;
    if (wr_at(A_IEN_CLR)) ien_d = ien_q & ~wmask;
    // Hardware overflow and software set are applied after the clear.
    ovf_d = (ovf_q & ~ovf_clr) | ovf_sw | hw_wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      sel_q <= '0;
      en_q  <= '0;
      ien_q <= '0;
      ovf_q <= '0;
    end else begin
      run_q <= run_d;
      sel_q <= sel_d;
      en_q  <= en_d;
      ien_q <= ien_d;
      ovf_q <= ovf_d;
    end
  end

  // Event counter bank.
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ev
    logic hit_sel;
    assign hit_sel = (sel_q == SEL_W'(i));
    pmon_evcnt #(.NUM_CODES(NUM_CODES)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_q & en_q[i]),
      .evt_i     (evt_i),
      .zero_i    (ev_zero),
      .type_we_i (wr_at(A_EVTYPE) & hit_sel),
      .val_we_i  (wr_at(A_EVVAL) & hit_sel),
      .wdata_i   (reg_wdata_i),
      .type_o    (ev_type[i]),
      .cnt_o     (ev_cnt[i]),
      .wrap_o    (ev_wrap[i])
    );
  end

  assign cyc_lo_we = wr_at(A_CYC_LO) | (wr_at(A_EVVAL) & sel_is_cyc);
  assign cyc_hi_we = wr_at(A_CYC_HI);

  pmon_cyccnt u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q & en_q[CYC_BIT]),
    .zero_i  (cyc_zero),
    .lo_we_i (cyc_lo_we),
    .hi_we_i (cyc_hi_we),
    .wdata_i (reg_wdata_i),
    .cnt_o   (cyc_cnt),
    .wrap_o  (cyc_wrap)
  );

  always_comb begin
    hw_wrap = '0;
    for (int i = 0; i < NUM_CTR; i++) hw_wrap[i] = ev_wrap[i];
    hw_wrap[CYC_BIT] = cyc_wrap;
  end

  // Indirect window: selected counter, cycle counter at 31, zero elsewhere.
  always_comb begin
    win_val  = '0;
    win_type = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (sel_q == SEL_W'(i)) begin
        win_val  = ev_cnt[i];
        win_type = 32'(ev_type[i]);
      end
    end
    if (sel_is_cyc) begin
      win_val  = cyc_cnt[CNT_W-1:0];
      win_type = 32'(CODE_CYCLES);
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:               reg_rdata_o = {IMPL_CODE, ID_CODE, 5'(NUM_CTR), 10'b0, run_q};
      A_EN_SET, A_EN_CLR:   reg_rdata_o = en_q;
      A_OVF_SET, A_OVF_CLR: reg_rdata_o = ovf_q;
      A_SEL:                reg_rdata_o = 32'(sel_q);
      A_IEN_SET, A_IEN_CLR: reg_rdata_o = ien_q;
      A_CYC_LO:             reg_rdata_o = cyc_cnt[CNT_W-1:0];
      A_CYC_HI:             reg_rdata_o = cyc_cnt[CYC_W-1:CNT_W];
      A_EVTYPE:             reg_rdata_o = win_type;
      A_EVVAL:              reg_rdata_o = win_val;
      A_CAP_LO:             reg_rdata_o = CAP_MAP[31:0];
      A_CAP_HI:             reg_rdata_o = CAP_MAP[63:32];
      default:              reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(ovf_q & ien_q);

  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ovf_q & $past(ovf_q & ~ovf_clr)) == $past(ovf_q & ~ovf_clr)));
  assert_irq_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_we_i) |=> irq_o);
  assert_ctrl_pulse_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_CTRL) |-> (reg_rdata_o[2:1] == 2'b00));
  assert_unimpl_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((en_q & ~VALID) == '0));
endmodule

// File: tb/pmon_unit_tb.sv
module pmon_unit_tb;
  import pmon_pkg::*;

  localparam logic [63:0] CAP = 64'h0000_0001_3E0A_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] evt = '0;
  logic        irq;

  always #4 clk = ~clk;  // 125 MHz

  pmon_unit #(.NUM_CTR(4), .NUM_CODES(64), .ID_CODE(8'h3C), .IMPL_CODE(8'h5A),
              .CAP_MAP(CAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq));

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  bit    pend = 1'b0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // Monitor: pops one expectation per flagged cycle, away from the edge.
  always @(negedge clk) begin
    #2;
    if (pend && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input pmon_addr_e a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input pmon_addr_e a, input logic [31:0] e, input string r);
    @(negedge clk);
    we = 1'b0; addr = a;
    q.push_back('{1'b0, e, r});
    pend = 1'b1;
    @(posedge clk); #1;
    pend = 1'b0;
  endtask

  task automatic chk_irq(input bit e, input string r);
    @(negedge clk);
    we = 1'b0;
    q.push_back('{1'b1, {31'b0, e}, r});
    pend = 1'b1;
    @(posedge clk); #1;
    pend = 1'b0;
  endtask

  task automatic pulse(input int code, input int n);
    @(negedge clk);
    evt[code] = 1'b1;
    repeat (n) @(negedge clk);
    evt[code] = 1'b0;
  endtask

  // Write to a register in the same clock as event 5 is high.
  task automatic wr_with_evt(input pmon_addr_e a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; evt[5] = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; evt[5] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL,    32'h5A3C_2000, "R1 ctrl word");
    rd(A_EVVAL,   32'h0, "R1 counter 0");
    rd(A_CYC_LO,  32'h0, "R1 cycle low");
    rd(A_OVF_CLR, 32'h0, "R1 overflow flags");
    rd(A_EN_SET,  32'h0, "R1 enables");
    chk_irq(1'b0, "R1 irq low");

    // R3 set/clear pair
    wr(A_EN_SET, 32'hFFFF_FFFF);
    rd(A_EN_SET, 32'h8000_000F, "R3 set read");
    rd(A_EN_CLR, 32'h8000_000F, "R3 clear addr read");
    wr(A_EN_CLR, 32'h0000_0002);
    rd(A_EN_SET, 32'h8000_000D, "R3 clear one bit");
    wr(A_EN_SET, 32'h0);
    rd(A_EN_SET, 32'h8000_000D, "R3 zero write no effect");
    wr(A_EN_CLR, 32'hFFFF_FFFF);

    // R12 capability bitmap
    rd(A_CAP_LO, CAP[31:0],  "R12 low half");
    rd(A_CAP_HI, CAP[63:32], "R12 high half");
    wr(A_CAP_LO, 32'h0);
    rd(A_CAP_LO, CAP[31:0],  "R12 write ignored");

    // R2 counting gated by global and own enable
    wr(A_SEL, 0);
    wr(A_EVTYPE, 5);
    rd(A_EVTYPE, 5, "R9 type window");
    wr(A_EN_SET, 1);
    wr(A_CTRL, 1);
    pulse(5, 3);
    wr(A_CTRL, 0);
    rd(A_EVVAL, 3, "R2 three event clocks");
    pulse(5, 4);
    rd(A_EVVAL, 3, "R2 global off holds");
    wr(A_EN_CLR, 1);
    wr(A_CTRL, 1);
    pulse(5, 2);
    wr(A_CTRL, 0);
    rd(A_EVVAL, 3, "R2 own enable off holds");

    // R4 code 0x11 counts clocks
    wr(A_SEL, 1);
    wr(A_EVTYPE, 32'h11);
    wr(A_EN_SET, 2);
    wr(A_CTRL, 1);
    repeat (4) @(posedge clk);
    wr(A_CTRL, 0);
    rd(A_EVVAL, 5, "R4 cycles event");
    wr(A_EN_CLR, 2);

    // R5 / R6 / R7 overflow and interrupt
    wr(A_SEL, 0);
    wr(A_EVVAL, 32'hFFFF_FFFE);
    wr(A_EN_SET, 1);
    wr(A_CTRL, 1);
    pulse(5, 2);
    wr(A_CTRL, 0);
    rd(A_EVVAL, 0, "R5 wrap to zero");
    rd(A_OVF_CLR, 1, "R5 flag bit 0");
    chk_irq(1'b0, "R7 no irq without enable");
    wr(A_IEN_SET, 1);
    chk_irq(1'b1, "R7 irq raised");
    rd(A_IEN_CLR, 1, "R7 enable readback");
    wr(A_OVF_CLR, 1);
    rd(A_OVF_CLR, 0, "R6 clear by ones");
    chk_irq(1'b0, "R7 irq dropped");
    wr(A_OVF_SET, 1);
    chk_irq(1'b1, "R6 forced flag irq");
    wr(A_OVF_CLR, 0);
    rd(A_OVF_CLR, 1, "R6 zero write no effect");

    // R6 hardware overflow beats same-cycle clear
    wr(A_EVVAL, 32'hFFFF_FFFF);
    wr(A_CTRL, 1);
    wr_with_evt(A_OVF_CLR, 1);
    wr(A_CTRL, 0);
    rd(A_OVF_CLR, 1, "R6 wrap wins over clear");
    rd(A_EVVAL, 0, "R5 wrapped with clear");
    wr(A_IEN_CLR, 32'hFFFF_FFFF);

    // R11 write beats same-cycle increment
    wr(A_OVF_CLR, 32'hFFFF_FFFF);
    wr(A_EVVAL, 32'hFFFF_FFFF);
    wr(A_CTRL, 1);
    wr_with_evt(A_EVVAL, 100);
    wr(A_CTRL, 0);
    rd(A_EVVAL, 100, "R11 written value");
    rd(A_OVF_CLR, 0, "R11 no overflow");

    // R8 event reset ahead of increment
    wr(A_CTRL, 1);
    wr_with_evt(A_CTRL, 3);
    rd(A_CTRL, 32'h5A3C_2001, "R8 pulse bits read zero");
    wr(A_CTRL, 0);
    rd(A_EVVAL, 0, "R8 counter 0 zeroed");
    wr(A_SEL, 1);
    rd(A_EVVAL, 0, "R8 counter 1 zeroed");

    // R9 / R10 selector window
    wr(A_SEL, 3);
    wr(A_EVVAL, 77);
    wr(A_SEL, 10);
    wr(A_EVVAL, 55);
    wr(A_EVTYPE, 9);
    rd(A_SEL, 10, "R9 selector readback");
    rd(A_EVVAL, 0, "R10 value reads zero");
    rd(A_EVTYPE, 0, "R10 type reads zero");
    wr(A_SEL, 3);
    rd(A_EVVAL, 77, "R10 counter 3 untouched");
    rd(A_EVTYPE, 0, "R10 type 3 untouched");
    wr(A_SEL, 31);
    rd(A_EVTYPE, 32'h11, "R9 index 31 type");

    // R13 / R5 cycle counter
    wr(A_EN_CLR, 32'hFFFF_FFFF);
    wr(A_OVF_CLR, 32'hFFFF_FFFF);
    wr(A_CYC_HI, 32'hFFFF_FFFF);
    wr(A_CYC_LO, 32'hFFFF_FFFF);
    rd(A_CYC_LO, 32'hFFFF_FFFF, "R13 low write");
    rd(A_CYC_HI, 32'hFFFF_FFFF, "R13 high write");
    wr(A_EN_SET, 32'h8000_0000);
    wr(A_CTRL, 1);
    wr(A_CTRL, 0);
    rd(A_CYC_LO, 0, "R5 cycle wrap low");
    rd(A_CYC_HI, 0, "R5 cycle wrap high");
    rd(A_OVF_CLR, 32'h8000_0000, "R5 flag bit 31");
    wr(A_CYC_LO, 32'hFFFF_FFFF);
    wr(A_CTRL, 1);
    wr(A_CTRL, 0);
    rd(A_CYC_HI, 1, "R5 carry into high");
    rd(A_CYC_LO, 0, "R5 carry low");
    wr(A_EVVAL, 40);
    rd(A_CYC_LO, 40, "R9 window 31 writes cycle");
    rd(A_EVVAL, 40, "R9 window 31 reads cycle");
    wr(A_CTRL, 4);
    rd(A_CYC_LO, 0, "R8 cycle reset low");
    rd(A_CYC_HI, 0, "R8 cycle reset high");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule